// File: doc/BRIEF.md
# Framed Nibble Request Receiver

This block sits on the target side of a narrow request link. It takes a 4-bit bus and a frame strobe, with one nibble on each clock, and rebuilds whole request packets from them. Nibbles are paired into bytes, low half first. The first byte of a packet carries the opcode and a size code. From these two fields the receiver works out, during reception, how many bytes the packet holds.

When the last byte arrives, the block presents the decoded packet on a valid/ready output: opcode, size, transaction tag, byte mask, 64-bit address and up to 64 bits of write payload. A malformed flag travels with each packet. A high frame strobe always starts a new packet, even in the middle of one. Nibbles seen while no packet is open are discarded.

Top module: `nib_req_rx`

## Requirements
- R1: After reset, `pkt_valid` and `pkt_overrun` are low.
- R2: The nibble sampled with `rx_frame` high is the low half of packet byte 0, and the next nibble is its high half. Each later byte likewise takes its low half first. Byte 1 appears on `pkt_txid` and byte 2 on `pkt_mask`.
- R3: Opcodes 0 and 1 are writes, with length 11 + 2^size bytes. Every other opcode gives an 11-byte packet. `pkt_valid` rises one clock after the high nibble of the last byte is sampled.
- R4: `pkt_addr` is built from packet bytes 3 to 10, with byte 3 in bits 7:0 and byte 10 in bits 63:56.
- R5: `pkt_data` holds payload bytes 11 onward, with byte 11 in bits 7:0. Bits beyond the payload are zero.
- R6: `pkt_malformed` is high with a packet in any of these cases:
  - byte 0 has bit 7, 6 or 3 set;
  - byte 3 has any of bits 2:0 set;
  - the opcode is not 0, 1 or 4.
- R7: A high `rx_frame` before the current packet is complete drops the partial packet and starts a new one, whatever the nibble phase.
- R8: Nibbles sampled while no packet is open and `rx_frame` is low produce no output.
- R9: While `pkt_valid` is high and `pkt_ready` is low, the output and all its fields hold steady. A packet is accepted on a clock where both are high.
- R10: If a packet completes while an earlier one is still held unaccepted, the new packet is discarded, the held one stays, and `pkt_overrun` goes high until acceptance.
- R11: `pkt_opcode` is bits 2:0 of byte 0 and `pkt_size` is bits 5:4 of byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one nibble per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_nib | input | 4 | Inbound nibble bus |
| rx_frame | input | 1 | High with the low nibble of a packet's first byte |
| pkt_ready | input | 1 | Consumer accepts the held packet |
| pkt_valid | output | 1 | A decoded packet is held |
| pkt_opcode | output | 3 | Opcode field |
| pkt_size | output | 2 | Size code (payload of 1, 2, 4 or 8 bytes) |
| pkt_txid | output | 8 | Transaction tag |
| pkt_mask | output | 8 | Byte mask |
| pkt_addr | output | 64 | Address, least significant byte first on the wire |
| pkt_data | output | 64 | Write payload, zero-filled above its size |
| pkt_malformed | output | 1 | Fixed-zero bit set or opcode not recognised |
| pkt_overrun | output | 1 | A completed packet was lost while one was held |

## Verification
The assertions assume one meaningful nibble per clock, with `rx_frame` treated as an exact marker of a byte-0 low nibble. They also assume that `pkt_ready` is a plain level from a consumer which does not rely on the output changing during a stall. The stimulus drives every input on the falling edge. It opens packets only with a frame pulse, cuts packets short at both even and odd nibble counts, and holds `pkt_ready` low across whole packets to force overruns. This keeps the byte counter within the longest packet and the stall conditions within what the hold checks expect.

// File: rtl/nrx_pkg.sv
`timescale 1ns/1ps
package nrx_pkg;
  localparam int NIB_W      = 4;
  localparam int BYTE_W     = 2 * NIB_W;
  localparam int HDR_BYTES  = 3;
  localparam int ADDR_BYTES = 8;
  localparam int DATA_BYTES = 8;
  localparam int FIX_BYTES  = HDR_BYTES + ADDR_BYTES;
  localparam int MAX_BYTES  = FIX_BYTES + DATA_BYTES;
  localparam int CNT_W      = $clog2(MAX_BYTES + 1);
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int DATA_W     = DATA_BYTES * BYTE_W;

  localparam logic [2:0] OPC_WR_ALL  = 3'd0;
  localparam logic [2:0] OPC_WR_MASK = 3'd1;
  localparam logic [2:0] OPC_RD      = 3'd4;

  typedef struct packed {
    logic [BYTE_W-1:0] hdr;
    logic [BYTE_W-1:0] txid;
    logic [BYTE_W-1:0] mask;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } pkt_t;

  function automatic logic carries_payload(input logic [2:0] opc);
    return (opc == OPC_WR_ALL) || (opc == OPC_WR_MASK);
  endfunction

  function automatic logic [CNT_W-1:0] pkt_len(input logic [BYTE_W-1:0] hdr);
    logic [CNT_W-1:0] pay;
    pay = CNT_W'(1) << hdr[5:4];
    return carries_payload(hdr[2:0]) ? CNT_W'(FIX_BYTES) + pay : CNT_W'(FIX_BYTES);
  endfunction

  function automatic logic is_malformed(input pkt_t p);
    logic bad_opc;
    bad_opc = !carries_payload(p.hdr[2:0]) && (p.hdr[2:0] != OPC_RD);
    return p.hdr[7] | p.hdr[6] | p.hdr[3] | (p.addr[2:0] != 3'b000) | bad_opc;
  endfunction
endpackage

// File: rtl/nrx_nib_pair.sv
`timescale 1ns/1ps
module nrx_nib_pair
  import nrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  nib,
  input  logic              frame,
  input  logic              done,
  output logic              sop,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_val
);
  logic             armed_q, armed_d;
  logic             hi_q, hi_d;
  logic [NIB_W-1:0] low_q;
  logic             low_en;

  always_comb begin
    sop      = frame;
    byte_vld = armed_q && !frame && hi_q;
    byte_val = {nib, low_q};
    low_en   = frame || (armed_q && !hi_q);
    armed_d  = armed_q;
    hi_d     = hi_q;
    if (frame) begin
      armed_d = 1'b1;
      hi_d    = 1'b1;
    end else if (armed_q) begin
      hi_d = !hi_q;
      if (done) armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      hi_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      hi_q    <= hi_d;
    end
  end

  always_ff @(posedge clk) begin
    if (low_en) low_q <= nib;
  end

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !frame) |-> !byte_vld);
endmodule

// File: rtl/nrx_assemble.sv
`timescale 1ns/1ps
module nrx_assemble
  import nrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sop,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              done,
  output pkt_t              pkt_next
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  pkt_t             cur_q;
  logic             cur_en;

  always_comb begin
    pkt_next = cur_q;
    if (cnt_q == CNT_W'(0)) pkt_next.hdr  = byte_val;
    if (cnt_q == CNT_W'(1)) pkt_next.txid = byte_val;
    if (cnt_q == CNT_W'(2)) pkt_next.mask = byte_val;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cnt_q == CNT_W'(HDR_BYTES + i)) pkt_next.addr[i*BYTE_W +: BYTE_W] = byte_val;
    for (int j = 0; j < DATA_BYTES; j++)
      if (cnt_q == CNT_W'(FIX_BYTES + j)) pkt_next.data[j*BYTE_W +: BYTE_W] = byte_val;
    done   = byte_vld && (cnt_q != CNT_W'(0)) && (cnt_q == pkt_len(cur_q.hdr) - CNT_W'(1));
    cur_en = sop || byte_vld;
    cnt_d  = cnt_q;
    if (sop)           cnt_d = CNT_W'(0);
    else if (byte_vld) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= CNT_W'(0);
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (cur_en) cur_q <= sop ? '0 : pkt_next;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_BYTES));
  // R3
  done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_q >= CNT_W'(FIX_BYTES - 1)));
endmodule

// File: rtl/nrx_out_hold.sv
`timescale 1ns/1ps
module nrx_out_hold
  import nrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  pkt_t pkt_in,
  input  logic ready,
  output logic valid,
  output logic overrun,
  output pkt_t pkt_out
);
  logic valid_d, ovr_d, load;

  always_comb begin
    load    = done && (!valid || ready);
    valid_d = valid;
    ovr_d   = overrun;
    if (load) begin
      valid_d = 1'b1;
      ovr_d   = 1'b0;
    end else if (done) begin
      ovr_d = 1'b1;
    end else if (valid && ready) begin
      valid_d = 1'b0;
      ovr_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      overrun <= 1'b0;
    end else begin
      valid   <= valid_d;
      overrun <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) pkt_out <= pkt_in;
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && $stable(pkt_out)));
  // R10
  overrun_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> valid);
  // R10
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && done) |=> overrun);
endmodule

// File: rtl/nib_req_rx.sv
`timescale 1ns/1ps
module nib_req_rx
  import nrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  rx_nib,
  input  logic              rx_frame,
  input  logic              pkt_ready,
  output logic              pkt_valid,
  output logic [2:0]        pkt_opcode,
  output logic [1:0]        pkt_size,
  output logic [BYTE_W-1:0] pkt_txid,
  output logic [BYTE_W-1:0] pkt_mask,
  output logic [ADDR_W-1:0] pkt_addr,
  output logic [DATA_W-1:0] pkt_data,
  output logic              pkt_malformed,
  output logic              pkt_overrun
);
  logic [1:0]        rst_sync;
  logic              rst_ln;
  logic              sop, byte_vld, done;
  logic [BYTE_W-1:0] byte_val;
  pkt_t              pkt_next, pkt_held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ln = rst_sync[1];

  nrx_nib_pair u_pair (
    .clk(clk), .rst_n(rst_ln), .nib(rx_nib), .frame(rx_frame), .done(done),
    .sop(sop), .byte_vld(byte_vld), .byte_val(byte_val));

  nrx_assemble u_asm (
    .clk(clk), .rst_n(rst_ln), .sop(sop), .byte_vld(byte_vld),
    .byte_val(byte_val), .done(done), .pkt_next(pkt_next));

  nrx_out_hold u_out (
    .clk(clk), .rst_n(rst_ln), .done(done), .pkt_in(pkt_next), .ready(pkt_ready),
    .valid(pkt_valid), .overrun(pkt_overrun), .pkt_out(pkt_held));

  always_comb begin
    pkt_opcode    = pkt_held.hdr[2:0];
    pkt_size      = pkt_held.hdr[5:4];
    pkt_txid      = pkt_held.txid;
    pkt_mask      = pkt_held.mask;
    pkt_addr      = pkt_held.addr;
    pkt_data      = pkt_held.data;
    pkt_malformed = is_malformed(pkt_held);
  end

  // R3
  complete_on_high_chk: assert property (@(posedge clk) disable iff (!rst_ln)
    $rose(pkt_valid) |-> !$past(rx_frame));
endmodule

// File: tb/tb_nib_req_rx.sv
`timescale 1ns/1ps
module tb_nib_req_rx;
  logic        clk, rst_n;
  logic [3:0]  rx_nib;
  logic        rx_frame, pkt_ready;
  logic        pkt_valid, pkt_malformed, pkt_overrun;
  logic [2:0]  pkt_opcode;
  logic [1:0]  pkt_size;
  logic [7:0]  pkt_txid, pkt_mask;
  logic [63:0] pkt_addr, pkt_data;

  nib_req_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_nib(rx_nib), .rx_frame(rx_frame),
    .pkt_ready(pkt_ready), .pkt_valid(pkt_valid), .pkt_opcode(pkt_opcode),
    .pkt_size(pkt_size), .pkt_txid(pkt_txid), .pkt_mask(pkt_mask),
    .pkt_addr(pkt_addr), .pkt_data(pkt_data), .pkt_malformed(pkt_malformed),
    .pkt_overrun(pkt_overrun));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;
  logic rdy = 1'b1;

  // behavioural reference state
  logic [7:0]  q[$];
  bit          m_open = 0, m_hi = 0, m_valid = 0, m_ovr = 0, m_mal = 0;
  logic [3:0]  m_low = 0;
  logic [2:0]  m_opc = 0;
  logic [1:0]  m_size = 0;
  logic [7:0]  m_txid = 0, m_mask = 0;
  logic [63:0] m_addr = 0, m_data = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_len(input logic [7:0] h);
    if (h[2:0] == 3'd0 || h[2:0] == 3'd1) return 11 + (1 << h[5:4]);
    return 11;
  endfunction

  task automatic compare();
    chk(pkt_valid == m_valid, "R3 valid", 64'(pkt_valid), 64'(m_valid));
    chk(pkt_overrun == m_ovr, "R10 overrun", 64'(pkt_overrun), 64'(m_ovr));
    if (m_valid) begin
      chk(pkt_opcode == m_opc && pkt_size == m_size, "R11 opcode/size",
          64'({pkt_opcode, pkt_size}), 64'({m_opc, m_size}));
      chk(pkt_txid == m_txid && pkt_mask == m_mask, "R2 txid/mask",
          64'({pkt_txid, pkt_mask}), 64'({m_txid, m_mask}));
      chk(pkt_addr == m_addr, "R4 addr", pkt_addr, m_addr);
      chk(pkt_data == m_data, "R5 data", pkt_data, m_data);
      chk(pkt_malformed == m_mal, "R6 malformed", 64'(pkt_malformed), 64'(m_mal));
    end
  endtask

  task automatic model(input logic [3:0] n, input logic f, input logic r);
    bit fin = 0;
    if (f) begin
      m_open = 1; m_hi = 1; m_low = n; q.delete();
    end else if (m_open) begin
      if (!m_hi) begin
        m_low = n; m_hi = 1;
      end else begin
        q.push_back({n, m_low}); m_hi = 0;
        if (q.size() >= 11 && q.size() == ref_len(q[0])) begin
          fin = 1; m_open = 0;
        end
      end
    end
    if (fin) begin
      if (!m_valid || r) begin
        m_valid = 1; m_ovr = 0;
        m_opc = q[0][2:0]; m_size = q[0][5:4]; m_txid = q[1]; m_mask = q[2];
        m_addr = 0; m_data = 0;
        for (int i = 0; i < 8; i++) m_addr = m_addr | (64'(q[3+i]) << (8*i));
        for (int i = 11; i < q.size(); i++) m_data = m_data | (64'(q[i]) << (8*(i-11)));
        m_mal = q[0][7] || q[0][6] || q[0][3] || (q[3][2:0] != 0) ||
                !(q[0][2:0] == 0 || q[0][2:0] == 1 || q[0][2:0] == 4);
      end else m_ovr = 1;
    end else if (m_valid && r) begin
      m_valid = 0; m_ovr = 0;
    end
  endtask

  task automatic step(input logic [3:0] n, input logic f);
    @(negedge clk);
    compare();
    rx_nib = n; rx_frame = f; pkt_ready = rdy;
    model(n, f, rdy);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(4'h5, 1'b0);
  endtask

  task automatic send(input logic [7:0] hdr, input logic [7:0] tid, input logic [7:0] msk,
                      input logic [63:0] adr, input logic [63:0] dat, input int nnib);
    logic [7:0] b[$];
    int total;
    b.push_back(hdr); b.push_back(tid); b.push_back(msk);
    for (int i = 0; i < 8; i++) b.push_back(adr[8*i +: 8]);
    for (int i = 0; i < 8; i++) b.push_back(dat[8*i +: 8]);
    total = (nnib < 0) ? 2 * ref_len(hdr) : nnib;
    for (int i = 0; i < total; i++)
      step(i[0] ? b[i/2][7:4] : b[i/2][3:0], i == 0);
  endtask

  initial begin
    #800000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; rx_nib = 0; rx_frame = 0; pkt_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(pkt_valid == 0 && pkt_overrun == 0, "R1 reset", 64'({pkt_valid, pkt_overrun}), 64'd0);
    // R8 idle nibbles ignored
    idle(12);
    chk(pkt_valid == 0, "R8 idle ignored", 64'(pkt_valid), 64'd0);
    // reads and writes of each size
    send(8'h34, 8'h11, 8'h00, 64'h1122_3344_5566_7788, 64'h0, -1);
    idle(3);
    for (int s = 0; s < 4; s++) begin
      send({2'b00, 2'(s), 4'h0}, 8'h20 + 8'(s), 8'hF0, 64'hDEAD_BEEF_0000_1238 + 64'(s*8),
           64'hA1B2_C3D4_E5F6_0718, -1);
      idle(2);
    end
    send(8'h21, 8'h77, 8'h0F, 64'h0000_0000_8000_0040, 64'h0123_4567_89AB_CDEF, -1);
    // back-to-back without gap
    send(8'h14, 8'h78, 8'h01, 64'h10, 64'h0, -1);
    send(8'h10, 8'h79, 8'h02, 64'h18, 64'h55AA, -1);
    idle(3);
    // R6 malformed headers and address
    send(8'h02, 8'h31, 8'h00, 64'h40, 64'h0, -1);
    idle(2);
    send(8'h84, 8'h32, 8'h00, 64'h40, 64'h0, -1);
    idle(2);
    send(8'h0C, 8'h33, 8'h00, 64'h40, 64'h0, -1);
    idle(2);
    send(8'h10, 8'h34, 8'h00, 64'h45, 64'h9999, -1);
    idle(2);
    // R7 restart mid packet at even and odd nibble counts
    rdy = 0;
    send(8'h30, 8'h41, 8'h00, 64'h80, 64'h1, 10);
    send(8'h34, 8'h42, 8'h00, 64'h88, 64'h0, 7);
    send(8'h04, 8'h43, 8'h00, 64'h90, 64'h0, -1);
    idle(2);
    chk(pkt_valid == 1 && pkt_txid == 8'h43, "R7 restart", 64'(pkt_txid), 64'h43);
    // R10 overrun: held packet stays, flag raised
    send(8'h04, 8'h44, 8'h00, 64'h98, 64'h0, -1);
    idle(3);
    chk(pkt_overrun == 1 && pkt_txid == 8'h43, "R10 overrun held",
        64'({pkt_overrun, pkt_txid}), 64'h143);
    rdy = 1;
    idle(3);
    chk(pkt_valid == 0 && pkt_overrun == 0, "R10 cleared on accept",
        64'({pkt_valid, pkt_overrun}), 64'd0);
    // R9 stall then accept during completion
    rdy = 0;
    send(8'h20, 8'h51, 8'hFF, 64'hA0, 64'hCAFE_F00D, -1);
    idle(4);
    rdy = 1;
    send(8'h04, 8'h52, 8'h00, 64'hA8, 64'h0, -1);
    idle(4);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule